// File: doc/BRIEF.md
# Eight-Point Fixed-Point Inverse DCT Butterfly

This block evaluates one dimension of an 8-point inverse DCT. Each transfer carries eight signed coefficients. The block multiplies them by seven fixed 16-bit cosine weights, combines them through an even/odd butterfly, and returns eight signed results. A separable 2-D transform runs the block twice: once over rows and once over columns, with a transpose done outside between the two passes.

Every multiply is a multiply-high that returns the integer floor of a·K/65536. Weights below 32768 use a plain signed-by-unsigned product. Larger weights are applied as a product with the weight reinterpreted as negative, and the operand is added back afterwards. Every sum wraps in the data width, as lane-wise 16-bit arithmetic does.

A mode bit travels with each transfer. In the first pass the raw butterfly sums are returned. In the final pass a bias input is added to the two even-part DC terms, and each result is shifted right arithmetically by a fixed amount. The edge is a valid/ready handshake into a short pipeline of one or two register stages that stalls as a whole.

Top module: `idct8_butterfly`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `in_ready` is 1 until a transfer is accepted.
- R2: Each multiply returns floor(a·K/65536), with K one of 64277, 60547, 54491, 46341, 36410, 25080, 12785 (weights 1 to 7). For a lone DC coefficient of 100 in the first pass, every lane outputs 70.
- R3: Lane i of `in_coef` and `out_data` sits at bits [16i+15:16i]. The odd part maps a lone coefficient 1000 in lane 1 to outputs (980, 829, 555, 195, -195, -555, -829, -980) in lanes 0 to 7.
- R4: When `in_final`=1, `in_bias` is added to both even DC terms after their weight-4 multiply, and every output is the wrapped sum shifted right arithmetically by 4. A lone DC of 100 with bias 8 gives 4 in all lanes, and a lone DC of -100 with bias 8 gives -4.
- R5: When `in_final`=0, `in_bias` has no effect on `out_data`.
- R6: All intermediate sums wrap modulo 2^16. Lanes 0 and 4 both at 32767 in the first pass give -2 in lanes 0, 3, 4 and 7 and 0 in the others.
- R7: With `out_ready` held high, a result appears on `out_valid` exactly 1+IN_REG cycles after its transfer is accepted.
- R8: While `out_valid`=1 and `out_ready`=0, `out_data` holds stable and `in_ready` is 0.
- R9: Under any pattern of back-pressure, every accepted transfer is delivered once, in order, with its own mode and bias applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Block can take a transfer this cycle |
| in_coef | input | 128 | Eight signed 16-bit coefficients, lane i at [16i+15:16i] |
| in_final | input | 1 | 1 = final pass (bias and shift), 0 = first pass |
| in_bias | input | 16 | Signed bias added to even DC terms in the final pass |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 128 | Eight signed 16-bit results, lane i at [16i+15:16i] |

## Verification
The bench builds the block with its defaults: 16-bit data, a final shift of 4, and the input register stage enabled. The two-stage pipeline this gives lets a stall hold one transfer at the output while a second waits in the input stage, so in-order delivery under back-pressure is tested with both stages full. The 16-bit width makes the wrap-around of the even-part sum reachable with two full-scale coefficients, and the weights' split into add-back and direct multiplies is covered by single-coefficient vectors and by pseudo-random full vectors.

// File: rtl/idct8_pkg.sv
package idct8_pkg;
   localparam int LANES = 8;
   localparam int KBITS = 16;

   function automatic int unsigned cos_k(input int idx);
      case (idx)
         1:       return 64277;
         2:       return 60547;
         3:       return 54491;
         4:       return 46341;
         5:       return 36410;
         6:       return 25080;
         7:       return 12785;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/idct8_mulhi.sv
module idct8_mulhi #(
   parameter int          DW = 16,
   parameter int unsigned K  = 46341
) (
   input  logic signed [DW-1:0] a,
   output logic signed [DW-1:0] p
);
   import idct8_pkg::*;
   localparam int PW   = DW + KBITS + 1;
   localparam int HALF = 1 << (KBITS - 1);

   if (K >= (1 << KBITS)) begin : g_bad_k
      $error("idct8_mulhi: weight does not fit in %0d bits", KBITS);
   end

   generate
      if (K >= HALF) begin : g_addback
         // weight read as negative; operand added back restores a*K
         localparam logic signed [PW-1:0] KS = PW'(int'(K) - (1 << KBITS));
         logic signed [PW-1:0] prod;
         assign prod = PW'(a) * KS;
         assign p    = a + DW'(prod >>> KBITS);
      end else begin : g_direct
         localparam logic signed [PW-1:0] KP = PW'(K);
         logic signed [PW-1:0] prod;
         assign prod = PW'(a) * KP;
         assign p    = DW'(prod >>> KBITS);
      end
   endgenerate
endmodule

// File: rtl/idct8_pipe_reg.sv
module idct8_pipe_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         d_valid,
   input  logic [W-1:0] d_data,
   output logic         q_valid,
   output logic [W-1:0] q_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_data  <= '0;
      end else if (en) begin
         q_valid <= d_valid;
         q_data  <= d_data;
      end
   end
endmodule

// File: rtl/idct8_core.sv
module idct8_core #(
   parameter int DW         = 16,
   parameter int POST_SHIFT = 4
) (
   input  logic [idct8_pkg::LANES*DW-1:0] coef,
   input  logic                           final_pass,
   input  logic signed [DW-1:0]           bias,
   output logic [idct8_pkg::LANES*DW-1:0] res
);
   import idct8_pkg::*;

   logic signed [DW-1:0] x [LANES];
   logic signed [DW-1:0] sum [LANES];

   for (genvar i = 0; i < LANES; i++) begin : g_unpack
      assign x[i] = coef[i*DW +: DW];
   end

   // odd-part products
   logic signed [DW-1:0] m1k1, m7k7, m1k7, m7k1, m3k3, m5k5, m5k3, m3k5;
   // even-part products
   logic signed [DW-1:0] m2k2, m6k6, m2k6, m6k2, msum4, mdif4;
   // second-level weight-4 products
   logic signed [DW-1:0] ad, bd;

   logic signed [DW-1:0] oa, ob, oc, od, a_m_c, b_m_d, cd, dd;
   logic signed [DW-1:0] s04, d04, rnd, ee, ff, gg, hh;
   logic signed [DW-1:0] ed, gd, fa, bh_d, fd, bh_s;

   idct8_mulhi #(.DW(DW), .K(cos_k(1))) u_m1k1 (.a(x[1]), .p(m1k1));
   idct8_mulhi #(.DW(DW), .K(cos_k(7))) u_m7k7 (.a(x[7]), .p(m7k7));
   idct8_mulhi #(.DW(DW), .K(cos_k(7))) u_m1k7 (.a(x[1]), .p(m1k7));
   idct8_mulhi #(.DW(DW), .K(cos_k(1))) u_m7k1 (.a(x[7]), .p(m7k1));
   idct8_mulhi #(.DW(DW), .K(cos_k(3))) u_m3k3 (.a(x[3]), .p(m3k3));
   idct8_mulhi #(.DW(DW), .K(cos_k(5))) u_m5k5 (.a(x[5]), .p(m5k5));
   idct8_mulhi #(.DW(DW), .K(cos_k(3))) u_m5k3 (.a(x[5]), .p(m5k3));
   idct8_mulhi #(.DW(DW), .K(cos_k(5))) u_m3k5 (.a(x[3]), .p(m3k5));
   idct8_mulhi #(.DW(DW), .K(cos_k(2))) u_m2k2 (.a(x[2]), .p(m2k2));
   idct8_mulhi #(.DW(DW), .K(cos_k(6))) u_m6k6 (.a(x[6]), .p(m6k6));
   idct8_mulhi #(.DW(DW), .K(cos_k(6))) u_m2k6 (.a(x[2]), .p(m2k6));
   idct8_mulhi #(.DW(DW), .K(cos_k(2))) u_m6k2 (.a(x[6]), .p(m6k2));
   idct8_mulhi #(.DW(DW), .K(cos_k(4))) u_ms4  (.a(s04),  .p(msum4));
   idct8_mulhi #(.DW(DW), .K(cos_k(4))) u_md4  (.a(d04),  .p(mdif4));
   idct8_mulhi #(.DW(DW), .K(cos_k(4))) u_mad  (.a(a_m_c), .p(ad));
   idct8_mulhi #(.DW(DW), .K(cos_k(4))) u_mbd  (.a(b_m_d), .p(bd));

   always_comb begin
      oa    = m1k1 + m7k7;
      ob    = m1k7 - m7k1;
      oc    = m3k3 + m5k5;
      od    = m5k3 - m3k5;
      a_m_c = oa - oc;
      b_m_d = ob - od;
      cd    = oa + oc;
      dd    = ob + od;

      s04   = x[0] + x[4];
      d04   = x[0] - x[4];
      rnd   = final_pass ? bias : '0;
      ee    = msum4 + rnd;
      ff    = mdif4 + rnd;
      gg    = m2k2 + m6k6;
      hh    = m2k6 - m6k2;

      ed    = ee - gg;
      gd    = ee + gg;
      fa    = ff + ad;
      bh_d  = bd - hh;
      fd    = ff - ad;
      bh_s  = bd + hh;

      sum[0] = gd + cd;
      sum[7] = gd - cd;
      sum[1] = fa + bh_s;
      sum[2] = fa - bh_s;
      sum[3] = ed + dd;
      sum[4] = ed - dd;
      sum[5] = fd + bh_d;
      sum[6] = fd - bh_d;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_out
      assign res[i*DW +: DW] = final_pass ? DW'(sum[i] >>> POST_SHIFT) : sum[i];
   end
endmodule

// File: rtl/idct8_butterfly.sv
module idct8_butterfly #(
   parameter int DW         = 16,
   parameter int POST_SHIFT = 4,
   parameter int IN_REG     = 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           in_valid,
   output logic                           in_ready,
   input  logic [idct8_pkg::LANES*DW-1:0] in_coef,
   input  logic                           in_final,
   input  logic [DW-1:0]                  in_bias,
   output logic                           out_valid,
   input  logic                           out_ready,
   output logic [idct8_pkg::LANES*DW-1:0] out_data
);
   import idct8_pkg::*;
   localparam int VW     = LANES * DW;
   localparam int PKW    = VW + DW + 1;
   localparam int STAGES = 1 + IN_REG;

   if (DW < KBITS) begin : g_bad_dw
      $error("idct8_butterfly: DW must be at least %0d", KBITS);
   end
   if (POST_SHIFT < 0 || POST_SHIFT >= DW) begin : g_bad_shift
      $error("idct8_butterfly: POST_SHIFT out of range");
   end
   if (IN_REG < 0 || IN_REG > 1) begin : g_bad_inreg
      $error("idct8_butterfly: IN_REG must be 0 or 1");
   end

   logic          advance;
   logic          s1_valid;
   logic [VW-1:0] s1_coef;
   logic          s1_final;
   logic [DW-1:0] s1_bias;
   logic [VW-1:0] core_res;

   // whole pipeline moves together whenever the output slot frees up
   assign advance  = !out_valid || out_ready;
   assign in_ready = advance;

   generate
      if (IN_REG != 0) begin : g_in_reg
         logic [PKW-1:0] pk_q;
         idct8_pipe_reg #(.W(PKW)) u_in (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (advance),
            .d_valid(in_valid),
            .d_data ({in_bias, in_final, in_coef}),
            .q_valid(s1_valid),
            .q_data (pk_q)
         );
         assign {s1_bias, s1_final, s1_coef} = pk_q;
      end else begin : g_in_wire
         assign s1_valid = in_valid;
         assign s1_coef  = in_coef;
         assign s1_final = in_final;
         assign s1_bias  = in_bias;
      end
   endgenerate

   idct8_core #(.DW(DW), .POST_SHIFT(POST_SHIFT)) u_core (
      .coef      (s1_coef),
      .final_pass(s1_final),
      .bias      (s1_bias),
      .res       (core_res)
   );

   idct8_pipe_reg #(.W(VW)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (advance),
      .d_valid(s1_valid),
      .d_data (core_res),
      .q_valid(out_valid),
      .q_data (out_data)
   );
endmodule

// File: rtl/idct8_chk.sv
module idct8_chk #(
   parameter int DW    = 16,
   parameter int DEPTH = 2
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           in_valid,
   input logic                           in_ready,
   input logic                           out_valid,
   input logic                           out_ready,
   input logic [idct8_pkg::LANES*DW-1:0] out_data
);
   logic [3:0] occ;
   logic       acc, rel;

   assign acc = in_valid && in_ready;
   assign rel = out_valid && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= '0;
      else        occ <= occ + {3'd0, acc} - {3'd0, rel};
   end

   AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> !out_valid); // R1
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
   AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready); // R8
   AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> occ != 4'd0); // R9
   AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= 4'(DEPTH)); // R9
endmodule

bind idct8_butterfly idct8_chk #(.DW(DW), .DEPTH(STAGES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_data (out_data)
);

// File: tb/idct8_butterfly_tb.sv
module idct8_butterfly_tb;
   localparam int K1 = 64277, K2 = 60547, K3 = 54491, K4 = 46341;
   localparam int K5 = 36410, K6 = 25080, K7 = 12785;
   localparam int NS = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [127:0] in_coef = '0;
   logic         in_final = 1'b0;
   logic [15:0]  in_bias = '0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [127:0] out_data;

   int total = 0;
   int fails = 0;
   logic [31:0] seed = 32'h1bad5eed;

   always #4 clk = ~clk;

   idct8_butterfly u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_coef(in_coef), .in_final(in_final), .in_bias(in_bias),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   function automatic int w16(input int v);
      logic signed [15:0] t;
      t = v[15:0];
      return int'(t);
   endfunction

   function automatic int mh(input int a, input int k);
      longint p;
      p = longint'(a) * longint'(k);
      return int'(p >>> 16);
   endfunction

   function automatic logic [127:0] model(input logic [127:0] c, input bit fin, input int bias);
      int x[8]; int y[8];
      int oa, ob, oc, od, ad, bd, cd, dd, ee, ff, gg, hh, r;
      logic [127:0] o;
      for (int i = 0; i < 8; i++) x[i] = w16(int'(c[i*16 +: 16]));
      r  = fin ? bias : 0;
      oa = w16(mh(x[1], K1) + mh(x[7], K7));
      ob = w16(mh(x[1], K7) - mh(x[7], K1));
      oc = w16(mh(x[3], K3) + mh(x[5], K5));
      od = w16(mh(x[5], K3) - mh(x[3], K5));
      ad = mh(w16(oa - oc), K4);
      bd = mh(w16(ob - od), K4);
      cd = w16(oa + oc);
      dd = w16(ob + od);
      ee = w16(mh(w16(x[0] + x[4]), K4) + r);
      ff = w16(mh(w16(x[0] - x[4]), K4) + r);
      gg = w16(mh(x[2], K2) + mh(x[6], K6));
      hh = w16(mh(x[2], K6) - mh(x[6], K2));
      y[0] = w16(w16(ee + gg) + cd);
      y[7] = w16(w16(ee + gg) - cd);
      y[1] = w16(w16(ff + ad) + w16(bd + hh));
      y[2] = w16(w16(ff + ad) - w16(bd + hh));
      y[3] = w16(w16(ee - gg) + dd);
      y[4] = w16(w16(ee - gg) - dd);
      y[5] = w16(w16(ff - ad) + w16(bd - hh));
      y[6] = w16(w16(ff - ad) - w16(bd - hh));
      for (int i = 0; i < 8; i++) begin
         if (fin) y[i] = y[i] >>> 4;
         o[i*16 +: 16] = y[i][15:0];
      end
      return o;
   endfunction

   function automatic logic [127:0] pack8(input int a0, input int a1, input int a2, input int a3,
                                           input int a4, input int a5, input int a6, input int a7);
      logic [127:0] o;
      o[15:0] = a0[15:0];    o[31:16] = a1[15:0];  o[47:32] = a2[15:0];  o[63:48] = a3[15:0];
      o[79:64] = a4[15:0];   o[95:80] = a5[15:0];  o[111:96] = a6[15:0]; o[127:112] = a7[15:0];
      return o;
   endfunction

   function automatic logic [31:0] rnd32(input logic [31:0] s);
      logic [31:0] t;
      t = s ^ (s << 13);
      t = t ^ (t >> 17);
      return t ^ (t << 5);
   endfunction

   task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
      total++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic check_bit(input string req, input logic got, input logic exp);
      total++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", req, got, exp);
      end
   endtask

   // one transfer on an idle pipeline, latency and data both checked
   task automatic run_one(input string req, input logic [127:0] c, input bit fin,
                          input int bias, input logic [127:0] exp);
      @(negedge clk);
      in_coef = c; in_final = fin; in_bias = bias[15:0]; in_valid = 1'b1; out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check_bit({req, " R7 not yet valid after 1 cycle"}, out_valid, 1'b0);
      @(negedge clk);
      check_bit({req, " R7 valid after 2 cycles"}, out_valid, 1'b1);
      check(req, out_data, exp);
   endtask

   task automatic t_reset();
      #1;
      check_bit("R1 out_valid in reset", out_valid, 1'b0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_bit("R1 out_valid after reset", out_valid, 1'b0);
      check_bit("R1 in_ready after reset", in_ready, 1'b1);
   endtask

   task automatic t_dc();
      run_one("R2 dc 100 first pass", pack8(100,0,0,0,0,0,0,0), 1'b0, 0,
              pack8(70,70,70,70,70,70,70,70));
   endtask

   task automatic t_odd();
      run_one("R3 lone lane1 1000", pack8(0,1000,0,0,0,0,0,0), 1'b0, 0,
              pack8(980,829,555,195,-195,-555,-829,-980));
   endtask

   task automatic t_final();
      run_one("R4 dc 100 bias 8 final", pack8(100,0,0,0,0,0,0,0), 1'b1, 8,
              pack8(4,4,4,4,4,4,4,4));
      run_one("R4 dc -100 bias 8 final", pack8(-100,0,0,0,0,0,0,0), 1'b1, 8,
              pack8(-4,-4,-4,-4,-4,-4,-4,-4));
   endtask

   task automatic t_bias_ignored();
      run_one("R5 bias 1234 first pass", pack8(100,0,0,0,0,0,0,0), 1'b0, 1234,
              pack8(70,70,70,70,70,70,70,70));
      run_one("R5 bias -777 first pass", pack8(0,1000,0,0,0,0,0,0), 1'b0, -777,
              pack8(980,829,555,195,-195,-555,-829,-980));
   endtask

   task automatic t_wrap();
      run_one("R6 wrap lanes 0,4 full scale", pack8(32767,0,0,0,32767,0,0,0), 1'b0, 0,
              pack8(-2,0,0,-2,-2,0,0,-2));
   endtask

   task automatic t_random();
      for (int n = 0; n < 8; n++) begin
         logic [127:0] c;
         bit fin;
         int b;
         for (int i = 0; i < 4; i++) begin
            seed = rnd32(seed);
            c[i*32 +: 32] = seed;
         end
         fin = n[0];
         seed = rnd32(seed);
         b = w16(int'(seed[15:0]));
         run_one("R3 R4 pseudo-random vector", c, fin, b, model(c, fin, b));
      end
   endtask

   task automatic t_stream();
      logic [127:0] vec [NS];
      logic [127:0] exp [NS];
      bit           fin [NS];
      int           bias [NS];
      int sent = 0, rcvd = 0;
      logic         prev_stall = 1'b0;
      logic [127:0] prev_data = '0;
      for (int n = 0; n < NS; n++) begin
         for (int i = 0; i < 4; i++) begin
            seed = rnd32(seed);
            vec[n][i*32 +: 32] = seed;
         end
         seed = rnd32(seed);
         fin[n]  = seed[20];
         bias[n] = w16(int'(seed[15:0]));
         exp[n]  = model(vec[n], fin[n], bias[n]);
      end
      for (int cyc = 0; cyc < 400 && rcvd < NS; cyc++) begin
         @(negedge clk);
         seed = rnd32(seed);
         out_ready = seed[3] | seed[7];
         in_valid  = (sent < NS);
         if (sent < NS) begin
            in_coef = vec[sent]; in_final = fin[sent]; in_bias = bias[sent][15:0];
         end
         #1;
         if (prev_stall) begin
            check_bit("R8 valid held during stall", out_valid, 1'b1);
            check("R8 data held during stall", out_data, prev_data);
         end
         if (out_valid && !out_ready)
            check_bit("R8 in_ready low during stall", in_ready, 1'b0);
         if (out_valid && out_ready) begin
            check("R9 in-order delivery", out_data, exp[rcvd]);
            rcvd++;
         end
         if (in_valid && in_ready) sent++;
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
      end
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b1;
      check_bit("R9 all transfers delivered", rcvd == NS, 1'b1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; fails++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      t_reset();
      t_dc();
      t_odd();
      t_final();
      t_bias_ignored();
      t_wrap();
      t_random();
      t_stream();
      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule